// File: doc/BRIEF.md
# Tick-Sampled Bit Probe Recorder

This block records a single binary signal over a run of ticks and writes one bit per tick into a packed byte memory. It watches a stream of keyed packets. Whenever a packet's key equals the key chosen for the run, the block keeps that packet's payload bit as the latest observed value.

Each tick arrives with a one-based tick number, which the block turns into a zero-based index. The block then waits a fixed number of clock cycles inside the tick, so that packets sent during that tick have time to arrive. It then takes the latest value and ORs it into the memory. The bit goes to byte index/8, at bit position index mod 8. The first sample therefore lands in bit 0 of byte 0.

A start pulse loads the run length and the key. It then zeroes only the bytes that the run will fill, with busy held high while it does so. When a tick's index reaches the run length, the block raises done and stops recording. A host reads the recorded bytes at any time through a synchronous read port.

Top module: `tick_bit_recorder`

## Requirements
- R1: After reset, busy, done and tickDrop are all low.
- R2: A start pulse loads runLength and inputKey and clears the latest value to 0. Busy is high from the next cycle until ceil(runLength/8) bytes have been written with zero. Ticks that arrive while busy is high record nothing.
- R3: The clear phase writes only bytes 0 to ceil(runLength/8)-1. Bytes at higher addresses keep their contents from earlier runs.
- R4: The latest value is replaced only by a packet with pktValid high and pktKey equal to the loaded key. Packets with any other key leave it unchanged.
- R5: A tick carrying tickNum n uses index n-1. Its sample is stored in byte (n-1)/8 at bit (n-1) mod 8, so bit 0 holds the earliest tick of each group of eight.
- R6: A sample is ORed into the stored byte. A 0 sample never clears a bit that is already 1, and the other bits of the byte are preserved.
- R7: The value sampled for a tick is the latest value SAMPLE_DELAY cycles after the tick is accepted. A matching packet that arrives inside that window is captured. A packet that arrives after the window is not captured for that tick.
- R8: A tick whose index is at least runLength raises done. Done stays high until the next start, and while done is high ticks change nothing in memory.
- R9: A tick that arrives while a previous sample is still pending is dropped. tickDrop is high in that same cycle, and nothing is recorded for the dropped tick.
- R10: rdData presents the byte at rdAddr one clock after rdAddr is applied.
- R11: busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run: load length and key, start clearing |
| runLength | input | LEN_W | Number of ticks to record (at most 8 x 2^ADDR_W) |
| inputKey | input | KEY_W | Key that selects packets for this run |
| pktValid | input | 1 | Packet present this cycle |
| pktKey | input | KEY_W | Packet key |
| pktBit | input | 1 | Packet payload bit |
| tickValid | input | 1 | Tick strobe |
| tickNum | input | CNT_W | One-based tick number |
| rdAddr | input | ADDR_W | Host read byte address |
| rdData | output | 8 | Host read data, one cycle after rdAddr |
| busy | output | 1 | Clear phase in progress |
| done | output | 1 | Run ended |
| tickDrop | output | 1 | Tick dropped because a sample was pending |

## Verification
An internal fault in this block first appears as a wrong bit in the readback memory. The bit can be in the wrong position, it can be cleared by a later 0 sample, or it can hold a value taken too early or too late within the tick. Any of these shows up on rdData within one cycle of reading the byte that the tick targeted.

A faulty state machine shows sooner, at busy, done or tickDrop, in the cycle after the start or tick edge that should have moved it. A faulty clear range shows only on a read of a byte just past the run. For that reason the bench fills such a byte in one run and reads it again after a shorter run.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_ARMED, ST_DELAY, ST_MERGE, ST_DONE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armRun;    // load key/length, reset clear pointer and latest value
    logic clrWr;     // write zero at clear pointer, advance
    logic loadIdx;   // capture zero-based tick index
    logic sampleRd;  // capture latest value, read target byte
    logic mergeWr;   // write OR-merged byte back
  } dpStrobe_t;
endpackage

// File: rtl/tbr_byte_ram.sv
module tbr_byte_ram #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [7:0]        wdA,
  output logic [7:0]        qA,
  input  logic [ADDR_W-1:0] addrB,
  output logic [7:0]        qB
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (weA) mem[addrA] <= wdA;
    qA <= mem[addrA];
    qB <= mem[addrB];
  end
endmodule

// File: rtl/tbr_datapath.sv
module tbr_datapath
  import tbr_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [KEY_W-1:0]  startKey,
  input  logic              pktValid,
  input  logic [KEY_W-1:0]  pktKey,
  input  logic              pktBit,
  input  logic [CNT_W-1:0]  tickNum,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              clrDone,
  output logic              idxBeyond
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [KEY_W-1:0] keyReg;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W:0]   clrCnt;
  logic [LEN_W:0]   byteCount;
  logic [CNT_W-1:0] tickIdx;
  logic [CNT_W-1:0] idxReg;
  logic             latestBit;
  logic             sampledBit;
  logic [ADDR_W-1:0] byteSel;
  logic [2:0]       bitSel;
  logic [7:0]       ramQ;
  logic [7:0]       mergedByte;
  logic             ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0]       ramWd;

  assign byteCount = ({1'b0, lenReg} + (LEN_W+1)'(7)) >> 3;
  assign clrDone   = (clrCnt >= byteCount) || (clrCnt >= (LEN_W+1)'(DEPTH));
  assign tickIdx   = tickNum - CNT_W'(1);
  assign idxBeyond = tickIdx >= CNT_W'(lenReg);
  assign byteSel   = idxReg[ADDR_W+2:3];
  assign bitSel    = idxReg[2:0];
  assign mergedByte = ramQ | (8'(sampledBit) << bitSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg     <= '0;
      lenReg     <= '0;
      clrCnt     <= '0;
      idxReg     <= '0;
      latestBit  <= 1'b0;
      sampledBit <= 1'b0;
    end else begin
      if (stb.armRun) begin
        keyReg    <= startKey;
        lenReg    <= startLen;
        clrCnt    <= '0;
        latestBit <= 1'b0;
      end else if (pktValid && pktKey == keyReg) begin
        latestBit <= pktBit;
      end
      if (stb.clrWr)    clrCnt     <= clrCnt + (LEN_W+1)'(1);
      if (stb.loadIdx)  idxReg     <= tickIdx;
      if (stb.sampleRd) sampledBit <= latestBit;
    end
  end

  assign ramWe   = stb.clrWr | stb.mergeWr;
  assign ramAddr = stb.clrWr ? clrCnt[ADDR_W-1:0] : byteSel;
  assign ramWd   = stb.clrWr ? 8'h00 : mergedByte;

  tbr_byte_ram #(.ADDR_W(ADDR_W)) i_ram (
    .clk  (clk),
    .weA  (ramWe),
    .addrA(ramAddr),
    .wdA  (ramWd),
    .qA   (ramQ),
    .addrB(rdAddr),
    .qB   (rdData)
  );
endmodule

// File: rtl/tbr_control.sv
module tbr_control
  import tbr_pkg::*;
#(
  parameter int SAMPLE_DELAY = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      tickValid,
  input  logic      clrDone,
  input  logic      idxBeyond,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      done,
  output logic      tickDrop
);
  localparam int DLY_W = $clog2(SAMPLE_DELAY + 1);

  ctrlState_t state, stateNext;
  logic [DLY_W-1:0] dlyCnt;

  always_comb begin
    stateNext = state;
    stb = '0;
    if (start) begin
      stb.armRun = 1'b1;
      stateNext  = ST_CLEAR;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          if (clrDone) stateNext = ST_ARMED;
          else stb.clrWr = 1'b1;
        end
        ST_ARMED: begin
          if (tickValid) begin
            if (idxBeyond) stateNext = ST_DONE;
            else begin
              stb.loadIdx = 1'b1;
              stateNext   = ST_DELAY;
            end
          end
        end
        ST_DELAY: begin
          if (dlyCnt == '0) begin
            stb.sampleRd = 1'b1;
            stateNext    = ST_MERGE;
          end
        end
        ST_MERGE: begin
          stb.mergeWr = 1'b1;
          stateNext   = ST_ARMED;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      dlyCnt <= '0;
    end else begin
      state <= stateNext;
      if (stb.loadIdx) dlyCnt <= DLY_W'(SAMPLE_DELAY - 1);
      else if (state == ST_DELAY && dlyCnt != '0) dlyCnt <= dlyCnt - DLY_W'(1);
    end
  end

  assign busy     = (state == ST_CLEAR);
  assign done     = (state == ST_DONE);
  assign tickDrop = tickValid && !start && (state == ST_DELAY || state == ST_MERGE);
endmodule

// File: rtl/tick_bit_recorder.sv
module tick_bit_recorder
  import tbr_pkg::*;
#(
  parameter int KEY_W        = 8,
  parameter int ADDR_W       = 4,
  parameter int CNT_W        = 16,
  parameter int LEN_W        = ADDR_W + 4,
  parameter int SAMPLE_DELAY = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  runLength,
  input  logic [KEY_W-1:0]  inputKey,
  input  logic              pktValid,
  input  logic [KEY_W-1:0]  pktKey,
  input  logic              pktBit,
  input  logic              tickValid,
  input  logic [CNT_W-1:0]  tickNum,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              done,
  output logic              tickDrop
);
  dpStrobe_t stb;
  logic clrDone;
  logic idxBeyond;

  tbr_control #(.SAMPLE_DELAY(SAMPLE_DELAY)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tickValid(tickValid),
    .clrDone  (clrDone),
    .idxBeyond(idxBeyond),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .tickDrop (tickDrop)
  );

  tbr_datapath #(
    .KEY_W (KEY_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .startLen (runLength),
    .startKey (inputKey),
    .pktValid (pktValid),
    .pktKey   (pktKey),
    .pktBit   (pktBit),
    .tickNum  (tickNum),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .clrDone  (clrDone),
    .idxBeyond(idxBeyond)
  );
endmodule

// File: rtl/tbr_checker.sv
module tbr_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic tickValid,
  input logic busy,
  input logic done,
  input logic tickDrop
);
  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R8
  done_from_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(tickValid));

  // R9
  drop_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickDrop |-> (tickValid && !busy && !done));
endmodule

bind tick_bit_recorder tbr_checker i_tbr_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .tickValid(tickValid),
  .busy     (busy),
  .done     (done),
  .tickDrop (tickDrop)
);

// File: tb/test_tick_bit_recorder.sv
module test_tick_bit_recorder;
  localparam int KEY_W = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W = 16;
  localparam int LEN_W = ADDR_W + 4;
  localparam int SAMPLE_DELAY = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] runLength = '0;
  logic [KEY_W-1:0] inputKey = '0;
  logic pktValid = 1'b0;
  logic [KEY_W-1:0] pktKey = '0;
  logic pktBit = 1'b0;
  logic tickValid = 1'b0;
  logic [CNT_W-1:0] tickNum = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic busy, done, tickDrop;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    int addr;
    logic [7:0] exp;
    string tag;
  } rdItem_t;
  rdItem_t sbQ[$];

  always #2 clk = ~clk;  // 250 MHz

  tick_bit_recorder #(
    .KEY_W(KEY_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .SAMPLE_DELAY(SAMPLE_DELAY)
  ) i_tick_bit_recorder (
    .clk(clk), .rstN(rstN), .start(start), .runLength(runLength),
    .inputKey(inputKey), .pktValid(pktValid), .pktKey(pktKey),
    .pktBit(pktBit), .tickValid(tickValid), .tickNum(tickNum),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done),
    .tickDrop(tickDrop)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one read item per cycle
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      rdItem_t it;
      it = sbQ.pop_front();
      check(rdData == it.exp, it.tag, rdData, it.exp);
    end
  end

  task automatic expectByte(input int addr, input logic [7:0] exp, input string tag);
    rdItem_t it;
    @(negedge clk); #1;
    rdAddr = ADDR_W'(addr);
    it.addr = addr; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart(input int len, input int key);
    @(negedge clk);
    start = 1'b1; runLength = LEN_W'(len); inputKey = KEY_W'(key);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendPkt(input int key, input bit b);
    @(negedge clk);
    pktValid = 1'b1; pktKey = KEY_W'(key); pktBit = b;
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic pulseTick(input int num);
    @(negedge clk);
    tickValid = 1'b1; tickNum = CNT_W'(num);
    @(negedge clk);
    tickValid = 1'b0;
  endtask

  task automatic tickWait(input int num);
    pulseTick(num);
    idle(SAMPLE_DELAY + 4);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    // R1 reset state
    check(busy == 0 && done == 0 && tickDrop == 0, "R1 reset outputs",
          {busy, done, tickDrop}, 0);
    rstN = 1'b1;
    idle(2);

    // R2 start run: length 20, key 5 -> clears 3 bytes
    doStart(20, 5);
    check(busy == 1, "R2 busy after start", busy, 1);
    @(negedge clk);
    pktValid = 1'b1; pktKey = 8'd5; pktBit = 1'b1;
    tickValid = 1'b1; tickNum = 16'd1;  // ignored during clear
    @(negedge clk);
    pktValid = 1'b0; tickValid = 1'b0;
    waitIdle();
    check(busy == 0 && done == 0, "R2 clear finished", {busy, done}, 0);
    expectByte(0, 8'h00, "R2 tick during clear ignored");
    expectByte(1, 8'h00, "R2 byte1 cleared");
    expectByte(2, 8'h00, "R2 byte2 cleared");

    // R4/R5 pattern
    tickWait(1);                          // latest=1 -> byte0 bit0
    sendPkt(6, 1'b0);                     // wrong key, stays 1
    tickWait(2);                          // byte0 bit1
    sendPkt(5, 1'b0);
    tickWait(3);                          // 0
    sendPkt(5, 1'b1);
    tickWait(10);                         // idx9 -> byte1 bit1
    tickWait(20);                         // idx19 -> byte2 bit3
    expectByte(0, 8'h03, "R4 R5 byte0 LSB-first, foreign key ignored");
    expectByte(1, 8'h02, "R5 byte1 index 9");
    expectByte(2, 8'h08, "R5 byte2 index 19");

    // R6 OR merge: 0 sample on an already set bit
    sendPkt(5, 1'b0);
    tickWait(1);
    expectByte(0, 8'h03, "R6 zero does not clear");

    // R7 sample window: packet inside the delay is captured
    pulseTick(5);                         // idx4
    idle(2);
    sendPkt(5, 1'b1);
    idle(SAMPLE_DELAY + 4);
    sendPkt(5, 1'b0);
    pulseTick(6);                         // idx5
    idle(SAMPLE_DELAY + 3);
    sendPkt(5, 1'b1);                     // too late for idx5
    idle(3);
    expectByte(0, 8'h13, "R7 late-in-window captured, after-window not");

    // R9 drop: second tick while the first is pending
    pulseTick(7);                         // idx6, latest=1
    @(negedge clk);
    tickValid = 1'b1; tickNum = 16'd8;
    #1;
    check(tickDrop == 1, "R9 tickDrop on pending tick", tickDrop, 1);
    @(negedge clk);
    tickValid = 1'b0;
    idle(SAMPLE_DELAY + 4);
    expectByte(0, 8'h53, "R9 dropped tick not recorded");

    // R8 end of run
    tickWait(21);                         // idx20 >= 20
    check(done == 1 && busy == 0, "R8 done raised", {busy, done}, 1);
    tickWait(15);                         // ignored, latest=1
    check(done == 1, "R8 done held", done, 1);
    expectByte(1, 8'h02, "R8 tick after done ignored");

    // R3 shorter run only clears byte 0; R10 read port
    doStart(8, 9);
    waitIdle();
    check(done == 0, "R8 start leaves done", done, 0);
    expectByte(0, 8'h00, "R3 byte0 cleared");
    expectByte(1, 8'h02, "R3 byte1 untouched beyond run");
    expectByte(2, 8'h08, "R10 byte2 readback");
    sendPkt(9, 1'b1);
    tickWait(8);                          // idx7 -> byte0 bit7
    expectByte(0, 8'h80, "R5 bit7 of byte0");
    tickWait(9);
    check(done == 1, "R8 done at length 8", done, 1);

    idle(4);
    finishRun();
  end
endmodule